// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block turns one wrapping-burst request into the sequence of byte addresses that the burst's beats use on an address channel. A request gives a start address, a beat size written as the base-2 logarithm of the bytes per beat, and a burst length in beats, and it is presented with a one-cycle start strobe. The block derives a window whose size is the total number of bytes in the burst and whose base is aligned to that size. It then hands out one address per beat over a valid/ready handshake. Each address steps up by one beat, and the next address returns to the window base when the step would pass the window's top byte.

A request is checked in the cycle it arrives. A start address that is not a multiple of the beat size is refused and is never rounded. A length other than 2, 4, 8 or 16 beats is also refused. A refused request raises a flag in that same cycle and starts no burst. While a burst is running, new start strobes are ignored.

Top module: `wrap_burst_agu`

## Requirements
- R1: After synchronous reset, `addr_valid_o`, `addr_last_o` and `illegal_o` are all low.
- R2: A legal start seen while idle makes `addr_valid_o` high on the next cycle, with `addr_o` equal to the start address.
- R3: The address advances only on a cycle where `addr_valid_o` and `addr_ready_i` are both high. While valid is high and ready is low, `addr_o`, `addr_last_o` and `addr_valid_o` hold.
- R4: Each next address is the current one plus 2^`beat_size_i` bytes. When that sum exceeds the window's top byte, the next address is the window base instead. The sum is formed without address-width overflow.
- R5: The window base is the start address with its low log2(total bytes) bits cleared. Here total bytes = 2^`beat_size_i` × `burst_len_i`. Every address issued lies between the base and base + total − 1, and every address is beat-aligned.
- R6: Exactly `burst_len_i` addresses are issued. `addr_last_o` is high with the final one only, and `addr_valid_o` is low on the cycle after the final address is accepted.
- R7: A start whose address has any of its low `beat_size_i` bits set raises `illegal_o` in the same cycle. No address is issued for it.
- R8: A start whose `burst_len_i` (a plain beat count) is not 2, 4, 8 or 16 raises `illegal_o` in the same cycle. No address is issued for it.
- R9: A start strobe that arrives while a burst is in progress is ignored. It does not raise `illegal_o` and does not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| start_addr_i | input | 32 | Byte address of the first beat |
| beat_size_i | input | 3 | log2 of bytes per beat |
| burst_len_i | input | 5 | Number of beats (2, 4, 8 or 16) |
| illegal_o | output | 1 | Request refused, same cycle as start |
| addr_valid_o | output | 1 | Address output is valid |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | 32 | Current beat byte address |
| addr_last_o | output | 1 | Current beat is the last of the burst |

## Verification
The in-line assertions check several properties on every cycle. They check that the output holds under backpressure, that every issued address is beat-aligned and stays inside the stored window, and that each accepted step either adds one beat or returns to the base. They also check that the block drops valid after the last accepted beat and that a refused request never leads to a valid address. Other properties can only be shown by the bench scenarios: the exact order of addresses for a given request, the count of beats, the cycle in which the first address appears, the refusal of each kind of bad request, and a start strobe being ignored mid-burst. These include the two fixed sequences 0x4, 0x8, 0xC, 0x0 and 56, 60, 48, 52, and a window that touches the top of the address space.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 3;
    localparam int LEN_W  = 5;
    localparam int LOG_W  = 3;
    localparam int SHIFT_W = 4;
    localparam int CNT_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t base;
        addr_t mask;
        addr_t step;
    } window_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // log2 of a supported beat count; zero marks an unsupported count
    function automatic logic [LOG_W-1:0] len_log2(input logic [LEN_W-1:0] len);
        logic [LOG_W-1:0] r;
        r = '0;
        for (int i = 1; i <= 4; i++) begin
            if (len == LEN_W'(1 << i)) r = LOG_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/wrap_req_check.sv
module wrap_req_check
    import wrap_pkg::*;
(
    input  addr_t               addr_i,
    input  logic [SIZE_W-1:0]   size_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic                ok_o,
    output logic                bad_len_o,
    output logic                misaligned_o,
    output window_t             win_o
);
    logic [LOG_W-1:0]   lg;
    logic [SHIFT_W-1:0] tot_shift;
    addr_t              beat_mask;

    always_comb begin
        lg           = len_log2(len_i);
        bad_len_o    = (lg == '0);
        beat_mask    = (addr_t'(1) << size_i) - addr_t'(1);
        misaligned_o = |(addr_i & beat_mask);
        ok_o         = !bad_len_o && !misaligned_o;
        tot_shift    = SHIFT_W'(size_i) + SHIFT_W'(lg);
        win_o.step   = addr_t'(1) << size_i;
        win_o.mask   = (addr_t'(1) << tot_shift) - addr_t'(1);
        win_o.base   = addr_i & ~win_o.mask;
    end
endmodule

// File: rtl/wrap_addr_step.sv
module wrap_addr_step
    import wrap_pkg::*;
(
    input  addr_t   cur_i,
    input  window_t win_i,
    output addr_t   nxt_o
);
    logic [ADDR_W:0] sum;
    logic [ADDR_W:0] top;

    always_comb begin
        sum   = {1'b0, cur_i} + {1'b0, win_i.step};
        top   = {1'b0, win_i.base | win_i.mask};
        nxt_o = (sum > top) ? win_i.base : sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/wrap_seq_ctrl.sv
module wrap_seq_ctrl
    import wrap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             req_ok_i,
    input  window_t          win_i,
    input  addr_t            start_addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  addr_t            nxt_i,
    input  logic             ready_i,
    output logic             valid_o,
    output addr_t            addr_o,
    output logic             last_o,
    output window_t          win_o
);
    state_e             state_q;
    addr_t              addr_q;
    window_t            win_q;
    logic [CNT_W-1:0]   beat_q;
    logic [CNT_W-1:0]   final_q;
    logic               launch;
    logic               fire;

    assign launch = (state_q == ST_IDLE) && start_i && req_ok_i;
    assign fire   = (state_q == ST_RUN) && ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            win_q   <= '0;
            beat_q  <= '0;
            final_q <= '0;
        end else if (launch) begin
            state_q <= ST_RUN;
            addr_q  <= start_addr_i;
            win_q   <= win_i;
            beat_q  <= '0;
            final_q <= CNT_W'(len_i - LEN_W'(1));
        end else if (fire) begin
            if (beat_q == final_q) begin
                state_q <= ST_IDLE;
            end else begin
                addr_q <= nxt_i;
                beat_q <= beat_q + CNT_W'(1);
            end
        end
    end

    assign valid_o = (state_q == ST_RUN);
    assign addr_o  = addr_q;
    assign last_o  = valid_o && (beat_q == final_q);
    assign win_o   = win_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(last_o));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        valid_o && ready_i && !last_o |=>
            (addr_o == $past(addr_o) + $past(win_q.step)) || (addr_o == win_q.base));

    assert_in_window_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((addr_o & ~win_q.mask) == win_q.base)
                 && ((addr_o & (win_q.step - addr_t'(1))) == '0));

    assert_done_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o && ready_i && last_o |=> !valid_o);
endmodule

// File: rtl/wrap_burst_agu.sv
module wrap_burst_agu
    import wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       start_addr_i,
    input  logic [2:0]        beat_size_i,
    input  logic [4:0]        burst_len_i,
    output logic              illegal_o,
    output logic              addr_valid_o,
    input  logic              addr_ready_i,
    output logic [31:0]       addr_o,
    output logic              addr_last_o
);
    logic    req_ok;
    logic    bad_len;
    logic    misaligned;
    window_t req_win;
    window_t run_win;
    addr_t   nxt_addr;

    wrap_req_check u_check (
        .addr_i       (start_addr_i),
        .size_i       (beat_size_i),
        .len_i        (burst_len_i),
        .ok_o         (req_ok),
        .bad_len_o    (bad_len),
        .misaligned_o (misaligned),
        .win_o        (req_win)
    );

    wrap_addr_step u_step (
        .cur_i (addr_o),
        .win_i (run_win),
        .nxt_o (nxt_addr)
    );

    wrap_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .req_ok_i     (req_ok),
        .win_i        (req_win),
        .start_addr_i (start_addr_i),
        .len_i        (burst_len_i),
        .nxt_i        (nxt_addr),
        .ready_i      (addr_ready_i),
        .valid_o      (addr_valid_o),
        .addr_o       (addr_o),
        .last_o       (addr_last_o),
        .win_o        (run_win)
    );

    assign illegal_o = start_i && !addr_valid_o && !req_ok;

    // R7 and R8: a refused request never produces an address
    assert_refused_idle_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> !addr_valid_o);

    // R8: an unsupported count seen while idle must be flagged
    assert_len_flag_R8: assert property (@(posedge clk) disable iff (rst)
        start_i && !addr_valid_o && bad_len |-> illegal_o);

    // R9: a strobe during a burst is never flagged
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> !illegal_o);

    // R1: the outputs are quiet in the cycle after reset
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !addr_valid_o && !addr_last_o);
endmodule

// File: tb/tb_wrap_burst_agu.sv
`timescale 1ns/1ps
module tb_wrap_burst_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [2:0]  beat_size_i = '0;
    logic [4:0]  burst_len_i = '0;
    logic        illegal_o;
    logic        addr_valid_o;
    logic        addr_ready_i = 1'b0;
    logic [31:0] addr_o;
    logic        addr_last_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] got [16];

    always #5 clk = ~clk;

    wrap_burst_agu dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .beat_size_i  (beat_size_i),
        .burst_len_i  (burst_len_i),
        .illegal_o    (illegal_o),
        .addr_valid_o (addr_valid_o),
        .addr_ready_i (addr_ready_i),
        .addr_o       (addr_o),
        .addr_last_o  (addr_last_o)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [2:0]  sz;
        logic [4:0]  ln;
        logic        stall;
        logic        poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0004, 3'd2, 5'd4,  1'b0, 1'b0},
        '{32'h0000_0038, 3'd2, 5'd4,  1'b1, 1'b1},
        '{32'h0000_001C, 3'd2, 5'd8,  1'b0, 1'b0},
        '{32'h0000_0101, 3'd0, 5'd2,  1'b1, 1'b0},
        '{32'h0000_007E, 3'd1, 5'd16, 1'b0, 1'b0},
        '{32'h0000_03F8, 3'd3, 5'd16, 1'b1, 1'b0},
        '{32'hFFFF_FFFC, 3'd2, 5'd4,  1'b0, 1'b0},
        '{32'h0000_0048, 3'd2, 5'd8,  1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [31:0] a, input logic [2:0] sz,
                             input logic [4:0] ln, input bit stall, input bit poke);
        logic [31:0] bytes;
        logic [31:0] tot;
        logic [31:0] base;
        logic [31:0] exp;
        logic [31:0] held;
        bytes = 32'd1 << sz;
        tot   = bytes * 32'(ln);
        base  = a & ~(tot - 32'd1);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; beat_size_i = sz; burst_len_i = ln;
        #1 chk("R7 legal request not flagged", 32'(illegal_o), 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 valid after start", 32'(addr_valid_o), 32'd1);
        chk("R2 first address", addr_o, a);
        for (int k = 0; k < int'(ln); k++) begin
            exp = base + ((a - base + 32'(k) * bytes) % tot);
            chk("R4 address order", addr_o, exp);
            chk("R5 inside window", 32'((addr_o - base) < tot), 32'd1);
            chk("R6 last flag", 32'(addr_last_o), 32'(k == int'(ln) - 1));
            chk("R6 valid during burst", 32'(addr_valid_o), 32'd1);
            got[k] = addr_o;
            if (stall && (k % 2 == 0)) begin
                addr_ready_i = 1'b0;
                held = addr_o;
                if (poke && k == 0) begin
                    start_i = 1'b1; start_addr_i = 32'h0000_0001;
                    beat_size_i = 3'd2; burst_len_i = 5'd4;
                    #1 chk("R9 busy start not flagged", 32'(illegal_o), 32'd0);
                end
                @(negedge clk);
                start_i = 1'b0;
                chk("R3 address held under stall", addr_o, held);
                chk("R3 valid held under stall", 32'(addr_valid_o), 32'd1);
            end
            addr_ready_i = 1'b1;
            @(negedge clk);
            addr_ready_i = 1'b0;
        end
        chk("R6 idle after last beat", 32'(addr_valid_o), 32'd0);
    endtask

    task automatic try_illegal(input string req, input logic [31:0] a,
                               input logic [2:0] sz, input logic [4:0] ln);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; beat_size_i = sz; burst_len_i = ln;
        #1 chk(req, 32'(illegal_o), 32'd1);
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " no burst"}, 32'(addr_valid_o), 32'd0);
        #1 chk({req, " flag one cycle"}, 32'(illegal_o), 32'd0);
        @(negedge clk);
        chk({req, " still idle"}, 32'(addr_valid_o), 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(addr_valid_o), 32'd0);
        chk("R1 last in reset", 32'(addr_last_o), 32'd0);
        chk("R1 illegal in reset", 32'(illegal_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(addr_valid_o), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_burst(VECS[v].a, VECS[v].sz, VECS[v].ln, VECS[v].stall, VECS[v].poke);
            if (v == 0) begin
                chk("R4 seq 0x4 beat0", got[0], 32'h4);
                chk("R4 seq 0x4 beat1", got[1], 32'h8);
                chk("R4 seq 0x4 beat2", got[2], 32'hC);
                chk("R4 seq 0x4 beat3", got[3], 32'h0);
            end
            if (v == 1) begin
                chk("R9 seq 56 beat0", got[0], 32'd56);
                chk("R9 seq 56 beat1", got[1], 32'd60);
                chk("R5 seq 56 beat2 base", got[2], 32'd48);
                chk("R9 seq 56 beat3", got[3], 32'd52);
            end
            if (v == 6) begin
                chk("R4 top of space folds", got[1], 32'hFFFF_FFF0);
            end
        end

        try_illegal("R7 misaligned 55", 32'd55, 3'd2, 5'd4);
        try_illegal("R7 misaligned half", 32'h0000_0103, 3'd1, 5'd8);
        try_illegal("R8 length 3", 32'h0000_0010, 3'd2, 5'd3);
        try_illegal("R8 length 1", 32'h0000_0010, 3'd2, 5'd1);
        try_illegal("R8 length 0", 32'h0000_0010, 3'd2, 5'd0);
        try_illegal("R8 length 31", 32'h0000_0000, 3'd0, 5'd31);

        run_burst(32'h0000_0020, 3'd2, 5'd2, 1'b0, 1'b0);
        chk("R4 two-beat fold", got[1], 32'h0000_0024);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule